// File: doc/BRIEF.md
# Serial FEC Block Boundary Synchronizer

This block takes a scrambled serial line, one bit per clock, that carries back-to-back 2112-bit forward error correction blocks. The line has no marker that shows where a block begins. The block finds the boundary by trial and error.

It places a candidate boundary and removes the per-block pseudo-random scrambling from the next 2112 bits. It then divides the result by the code's generator polynomial. A zero remainder means the 2080 message bits and the 32 parity bits agree. When a candidate fails during the search, one incoming bit is dropped, which moves the boundary one bit later, and the search tries again.

After a run of good blocks at one offset, the block declares lock. From then on, isolated failures are only reported. Only a long run of failures drops lock and restarts the search. The downstream decoder uses the block-start strobe, the per-block verdict and the lock flag to frame the stream. Error correction is not part of this block.

Top module: `fec_block_sync`

## Requirements
- R1: While `rst` is high at a rising edge, `blk_lock`, `blk_start` and `blk_done` are low after that edge. The bit sampled in the first cycle after reset is dropped. The first candidate block begins with the bit after it.
- R2: Each received bit is XORed with a pseudo-random bit before checking. The 58-bit state `s` is set to all ones at the first bit of every candidate block. The pseudo-random bit is `s[57]`. After each bit, `s` becomes `{s[56:0], s[57]^s[38]}`.
- R3: The descrambled bits of a candidate are treated as a polynomial, with the first bit as the highest power. This polynomial is divided by x^32+x^23+x^21+x^11+x^2+1. The block is good exactly when the remainder is zero. `blk_done` pulses for one cycle after the edge that samples the block's last bit, and `blk_ok` gives the verdict in that cycle.
- R4: A bad block while unlocked drops the next incoming bit (a slip), so the next `blk_start` comes two cycles after `blk_done` instead of one.
- R5: `blk_lock` rises after `GOOD_TO_LOCK` (default 4) consecutive good blocks at one offset. It rises in the same cycle as the `blk_done` of the last of them.
- R6: While locked, a bad block drops no bit: the next `blk_start` follows `blk_done` by one cycle. A single good block clears the run of bad blocks.
- R7: While locked, `BAD_TO_UNLOCK` (default 8) consecutive bad blocks drop `blk_lock` in the cycle of the last one's `blk_done`. That bad block then slips, and the search restarts.
- R8: `blk_start` pulses for one cycle after the edge that samples the first bit of a candidate block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one line bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit | input | 1 | Scrambled serial line bit |
| blk_lock | output | 1 | High while the block boundary is locked |
| blk_start | output | 1 | One-cycle strobe: first bit of a candidate block taken |
| blk_done | output | 1 | One-cycle strobe: candidate block complete |
| blk_ok | output | 1 | Parity verdict, valid while `blk_done` is high |

## Verification
Each block result appears one cycle after the edge that takes its last bit. The strobes (`blk_start`, `blk_done`) and the lock change in that cycle are due one cycle after the edge that samples the bit concerned. The bench samples every output at the falling edge between those clock edges.

A model in the bench tracks the `blk_done` events. It checks that `blk_start` arrives one or two samples later, depending on whether a slip is due. It also checks that each lock change coincides with the `blk_done` that completes the required run.

Lock from an unknown offset is checked against a bound computed from the block length. It takes one slip per wrong offset plus the good run.

// File: rtl/fec_sync_pkg.sv
package fec_sync_pkg;

    localparam int PAR_W = 32;
    localparam logic [PAR_W-1:0] GEN_POLY = 32'h00A0_0805;

    localparam int PN_W   = 58;
    localparam int PN_TAP = 38;
    localparam logic [PN_W-1:0] PN_SEED = '1;

    typedef enum logic [1:0] {
        ST_RESET  = 2'd0,
        ST_TEST   = 2'd1,
        ST_SLIP   = 2'd2,
        ST_LOCKED = 2'd3
    } sync_state_e;

    typedef struct packed {
        logic done;
        logic ok;
        logic start;
    } blk_status_t;

    function automatic logic [PN_W-1:0] pn_advance(input logic [PN_W-1:0] s);
        return {s[PN_W-2:0], s[PN_W-1] ^ s[PN_TAP]};
    endfunction

    function automatic logic [PAR_W-1:0] div_shift(input logic [PAR_W-1:0] r, input logic b);
        logic [PAR_W-1:0] t;
        t = {r[PAR_W-2:0], b};
        if (r[PAR_W-1]) t = t ^ GEN_POLY;
        return t;
    endfunction

endpackage

// File: rtl/fec_pn_descrambler.sv
module fec_pn_descrambler
    import fec_sync_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  logic first,
    input  logic line_bit,
    output logic plain_bit
);
    logic [PN_W-1:0] pn_q;
    logic [PN_W-1:0] pn_cur;

    // reseed at every candidate start
    assign pn_cur    = first ? PN_SEED : pn_q;
    assign plain_bit = line_bit ^ pn_cur[PN_W-1];

    always_ff @(posedge clk) begin
        if (rst)       pn_q <= PN_SEED;
        else if (take) pn_q <= pn_advance(pn_cur);
    end
endmodule

// File: rtl/fec_parity_check.sv
module fec_parity_check
    import fec_sync_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  logic first,
    input  logic plain_bit,
    output logic rem_zero
);
    logic [PAR_W-1:0] rem_q;
    logic [PAR_W-1:0] rem_nxt;

    assign rem_nxt  = div_shift(first ? '0 : rem_q, plain_bit);
    assign rem_zero = (rem_nxt == '0);

    always_ff @(posedge clk) begin
        if (rst)       rem_q <= '0;
        else if (take) rem_q <= rem_nxt;
    end
endmodule

// File: rtl/fec_lock_fsm.sv
module fec_lock_fsm
    import fec_sync_pkg::*;
#(
    parameter int GOOD_TO_LOCK  = 4,
    parameter int BAD_TO_UNLOCK = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic blk_end,
    input  logic blk_good,
    output logic take,
    output logic locked
);
    localparam int GW = $clog2(GOOD_TO_LOCK + 1);
    localparam int BW = $clog2(BAD_TO_UNLOCK + 1);

    sync_state_e state_q, state_n;
    logic [GW-1:0] good_q, good_n;
    logic [BW-1:0] bad_q, bad_n;

    always_comb begin
        state_n = state_q;
        good_n  = good_q;
        bad_n   = bad_q;
        case (state_q)
            ST_RESET: begin
                state_n = ST_TEST;
                good_n  = '0;
                bad_n   = '0;
            end
            ST_TEST: begin
                if (blk_end) begin
                    if (!blk_good) begin
                        good_n  = '0;
                        state_n = ST_SLIP;
                    end else if (good_q == GW'(GOOD_TO_LOCK - 1)) begin
                        good_n  = '0;
                        bad_n   = '0;
                        state_n = ST_LOCKED;
                    end else begin
                        good_n = good_q + 1'b1;
                    end
                end
            end
            ST_SLIP: state_n = ST_TEST;
            default: begin
                if (blk_end) begin
                    if (blk_good) begin
                        bad_n = '0;
                    end else if (bad_q == BW'(BAD_TO_UNLOCK - 1)) begin
                        bad_n   = '0;
                        state_n = ST_SLIP;
                    end else begin
                        bad_n = bad_q + 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RESET;
            good_q  <= '0;
            bad_q   <= '0;
        end else begin
            state_q <= state_n;
            good_q  <= good_n;
            bad_q   <= bad_n;
        end
    end

    assign take   = (state_q == ST_TEST) || (state_q == ST_LOCKED);
    assign locked = (state_q == ST_LOCKED);
endmodule

// File: rtl/fec_block_sync.sv
module fec_block_sync
    import fec_sync_pkg::*;
#(
    parameter int BLK_BITS      = 2112,
    parameter int GOOD_TO_LOCK  = 4,
    parameter int BAD_TO_UNLOCK = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_bit,
    output logic blk_lock,
    output logic blk_start,
    output logic blk_done,
    output logic blk_ok
);
    localparam int CW = $clog2(BLK_BITS);

    logic [CW-1:0] pos_q;
    logic take, first, last, plain, rem_zero;
    blk_status_t stat_q;

    assign first = take && (pos_q == '0);
    assign last  = take && (pos_q == CW'(BLK_BITS - 1));

    // counter idles to zero outside TEST/LOCKED: that is the slip
    always_ff @(posedge clk) begin
        if (rst || !take) pos_q <= '0;
        else              pos_q <= last ? '0 : pos_q + 1'b1;
    end

    fec_pn_descrambler u_pn (
        .clk(clk), .rst(rst), .take(take), .first(first),
        .line_bit(rx_bit), .plain_bit(plain)
    );

    fec_parity_check u_par (
        .clk(clk), .rst(rst), .take(take), .first(first),
        .plain_bit(plain), .rem_zero(rem_zero)
    );

    fec_lock_fsm #(
        .GOOD_TO_LOCK(GOOD_TO_LOCK), .BAD_TO_UNLOCK(BAD_TO_UNLOCK)
    ) u_fsm (
        .clk(clk), .rst(rst), .blk_end(last), .blk_good(rem_zero),
        .take(take), .locked(blk_lock)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
        end else begin
            stat_q.start <= first;
            stat_q.done  <= last;
            stat_q.ok    <= last && rem_zero;
        end
    end

    assign blk_start = stat_q.start;
    assign blk_done  = stat_q.done;
    assign blk_ok    = stat_q.ok;
endmodule

// File: rtl/fec_block_sync_chk.sv
module fec_block_sync_chk (
    input logic clk,
    input logic rst,
    input logic blk_lock,
    input logic blk_start,
    input logic blk_done,
    input logic blk_ok
);
    a_r5_lock_on_good: assert property (@(posedge clk) disable iff (rst)
        $rose(blk_lock) |-> (blk_done && blk_ok));

    a_r7_unlock_on_bad: assert property (@(posedge clk) disable iff (rst)
        ($fell(blk_lock) && !$past(rst)) |-> (blk_done && !blk_ok));

    a_r8_strobes_apart: assert property (@(posedge clk) disable iff (rst)
        !(blk_start && blk_done));

    a_r6_locked_no_slip: assert property (@(posedge clk) disable iff (rst)
        (blk_done && blk_lock) |=> blk_start);

    a_r4_search_slip: assert property (@(posedge clk) disable iff (rst)
        (blk_done && !blk_ok && !blk_lock) |=> !blk_start);

    a_r3_ok_only_with_done: assert property (@(posedge clk) disable iff (rst)
        blk_ok |-> blk_done);
endmodule

bind fec_block_sync fec_block_sync_chk u_chk (
    .clk(clk), .rst(rst), .blk_lock(blk_lock), .blk_start(blk_start),
    .blk_done(blk_done), .blk_ok(blk_ok)
);

// File: tb/fec_block_sync_test.sv
module fec_block_sync_test;
    localparam int BLK  = 96;
    localparam int NGOOD = 4;
    localparam int NBAD  = 8;
    localparam logic [31:0] GP = 32'h00A0_0805;
    localparam int NVEC = 4;
    localparam int OFFS [NVEC] = '{0, 1, 50, 95};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_bit = 1'b0;
    logic blk_lock, blk_start, blk_done, blk_ok;

    always #5 clk = ~clk;

    fec_block_sync #(.BLK_BITS(BLK), .GOOD_TO_LOCK(NGOOD), .BAD_TO_UNLOCK(NBAD)) uut (
        .clk(clk), .rst(rst), .rx_bit(rx_bit), .blk_lock(blk_lock),
        .blk_start(blk_start), .blk_done(blk_done), .blk_ok(blk_ok)
    );

    int n_chk = 0;
    int n_bad = 0;
    logic [BLK-1:0] tx_blk;
    int tx_idx = 0;
    int garbage = 0;
    logic [31:0] corrupt_seq = '0;
    int since_done = 0;
    bit gap_pend = 0;
    int exp_gap = 1;
    int run_good = 0;
    int run_bad = 0;
    logic lock_prev = 1'b0;
    bit in_rst = 1;
    int falls = 0;

    task automatic check(input bit cond, input string req, input int act, input int exp);
        n_chk++;
        if (!cond) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // encode, then scramble, one block; optionally flip one bit
    task automatic build_block();
        logic [31:0] p;
        logic [57:0] s;
        logic fb;
        logic [BLK-1:0] c;
        p = '0;
        for (int k = 0; k < BLK - 32; k++) begin
            c[k] = 1'($urandom);
            fb = p[31] ^ c[k];
            p = {p[30:0], 1'b0} ^ (fb ? GP : 32'h0);
        end
        for (int k = 0; k < 32; k++) c[BLK-32+k] = p[31-k];
        s = '1;
        for (int k = 0; k < BLK; k++) begin
            tx_blk[k] = c[k] ^ s[57];
            s = {s[56:0], s[57] ^ s[38]};
        end
        if (corrupt_seq[0]) tx_blk[$urandom_range(BLK-1, 0)] ^= 1'b1;
        corrupt_seq = corrupt_seq >> 1;
    endtask

    task automatic step();
        @(negedge clk);
        if (!in_rst) begin
            since_done++;
            if (blk_start && gap_pend) begin
                // R4 / R6: slip gap after done
                check(since_done == exp_gap, exp_gap == 2 ? "R4" : "R6", since_done, exp_gap);
                gap_pend = 0;
            end
            if (blk_done) begin
                since_done = 0;
                gap_pend = 1;
                exp_gap = (!blk_ok && !blk_lock) ? 2 : 1;
                if (blk_ok) begin run_good++; run_bad = 0; end
                else begin run_bad++; run_good = 0; end
            end
            if (blk_lock && !lock_prev)
                check(blk_done && blk_ok && run_good == NGOOD, "R5", run_good, NGOOD);
            if (!blk_lock && lock_prev) begin
                falls++;
                check(blk_done && !blk_ok && run_bad == NBAD, "R7", run_bad, NBAD);
            end
        end
        lock_prev = blk_lock;
        if (garbage > 0) begin
            rx_bit = 1'($urandom);
            garbage--;
        end else begin
            rx_bit = tx_blk[tx_idx];
            tx_idx++;
            if (tx_idx == BLK) begin
                tx_idx = 0;
                build_block();
            end
        end
    endtask

    task automatic do_reset(input int off);
        rst = 1'b1;
        in_rst = 1;
        for (int i = 0; i < 3; i++) step();
        // R1: reset state
        check(!blk_lock && !blk_start && !blk_done, "R1", {blk_lock, blk_start, blk_done}, 0);
        garbage = off;
        tx_idx = 0;
        corrupt_seq = '0;
        build_block();
        gap_pend = 0;
        run_good = 0;
        run_bad = 0;
        lock_prev = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        in_rst = 0;
    endtask

    task automatic wait_lock(input int bound, input string req);
        int n;
        n = 0;
        while (!blk_lock && n < bound) begin step(); n++; end
        check(blk_lock == 1'b1, req, n, bound);
    endtask

    initial begin
        int bound;
        bound = (BLK + 1) * (BLK + NGOOD + 3) + BLK;
        // table walk: unknown start offsets (R2, R3 via lock at a correct boundary)
        for (int v = 0; v < NVEC; v++) begin
            do_reset(OFFS[v]);
            wait_lock(bound + OFFS[v], "R2/R3 lock from offset");
            for (int i = 0; i < 3 * BLK; i++) step();
            check(blk_lock == 1'b1 && run_bad == 0, "R3 clean stream stays good", run_bad, 0);
        end
        // R8: start strobe period BLK while locked
        begin
            int t;
            while (!blk_start) step();
            t = 0;
            step();
            while (!blk_start) begin step(); t++; end
            check(t + 1 == BLK, "R8", t + 1, BLK);
        end
        // R6: 7 bad, 1 good, 7 bad: still locked
        corrupt_seq = 32'h0000_7F7F;
        for (int i = 0; i < 20 * BLK; i++) step();
        check(blk_lock == 1'b1 && falls == 0, "R6", falls, 0);
        // R7: 8 bad in a row drop lock
        corrupt_seq = 32'h0000_00FF;
        for (int i = 0; i < 11 * BLK; i++) step();
        check(falls == 1, "R7", falls, 1);
        check(blk_lock == 1'b0, "R7 searching", blk_lock, 0);
        // R4: search again after loss, relock
        wait_lock(bound, "R4 relock");
        // R1: reset while locked
        rst = 1'b1;
        in_rst = 1;
        step();
        check(!blk_lock && !blk_done && !blk_start, "R1 reset from lock", blk_lock, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule